// File: doc/BRIEF.md
# Fast-Off Idle Timer SMI Generator

This block is a power-management idle timer. A reload count register loads a down-counter. A prescaler, driven from the PCI clock, ticks that counter once per selected period. When the counter runs out, the block pulses a system-management interrupt (SMI) request, sets an expiry bit in a status register, and reloads itself. The timer therefore fires periodically until software stops it. A second source can also raise the SMI: a strobe that marks a write to the power-management software port. It sets a separate status bit, but only when software has armed it through two enable bits.

Software reaches the block through a plain byte-wide register port. Writes are strobed with `wr_en_i`, and reads are combinational from `rd_addr_i`. Status bits are cleared by writing an AND mask: a zero in a bit position clears that bit, and a one leaves it as it is. Rewriting the control register or the count register restarts the whole timing chain. The block has no data stream, so none of its pins uses a handshake. The SMI output is a bare pulse, and routing it to the processor is left to the surrounding logic.

Register addresses on `wr_addr_i`/`rd_addr_i`: 0 control, 1 SMI enable, 2 event flags A, 3 event flags B, 4 event flags C, 5 reload count, 6 status, 7 unused.

Top module: `fastoff_smi_timer`

## Requirements
- R1: After reset, the control register reads 08h, the reload count reads 0Fh, every other register reads 00h and `smi_o` is low.
- R2: Each register keeps only some of the bits written to it. Control keeps bits 4:0, event flags A clears bit 2, and event flags C keeps bits 7:5. SMI enable, event flags B and the reload count keep all 8 bits. Address 7 always reads 00h.
- R3: With control bits 4:3 = 10b the counter ticks every clock. After a write that loads count N, `smi_o` first goes high on the (N+1)th rising edge after the write edge and stays high for one cycle. With N = 0 it is high on every cycle.
- R4: With control bits 4:3 = 11b one tick takes PRE_LO_DIV clocks, so the first SMI comes (N+1)·PRE_LO_DIV edges after the write. With 00b one tick takes PRE_LO_DIV·PRE_HI_DIV clocks. The defaults are 32768 and 60000.
- R5: On each expiry the block sets status bit 5 and reloads the counter with count+1, so that SMIs repeat every (N+1) ticks.
- R6: With control bits 4:3 = 01b the timer is stopped. No expiry occurs and the status bits do not change.
- R7: A write to the control register or to the count register reloads the counter and restarts the prescaler from zero. Any time already counted is discarded.
- R8: A status write ANDs the written byte into the register. An event that sets a bit in the same cycle wins over the clear.
- R9: A strobe on `apm_wr_i` sets status bit 7 and pulses `smi_o` on the next edge, but only when control bit 0 and SMI enable bit 7 are both 1. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| apm_wr_i | input | 1 | Power-management software port write strobe |
| smi_o | output | 1 | SMI request pulse |

## Verification
The bench measures the edge count from the write to the first SMI in each period mode. An off-by-one in the plus-one reload would show up as an interval of N or N+2 ticks, and a missing prescaler stage would show up as a wrong multiple. It rewrites the count register and the control register part way through a period. A design that forgot to restart the prescaler would fire early. It sets and clears a status bit in the same cycle, so a clear that took priority would lose an event. It also strobes the software port with each enable missing in turn, and a loose qualifier would raise a spurious SMI or a spurious bit 7.

// File: rtl/fastoff_pkg.sv
package fastoff_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SMIEN = 3'd1;
  localparam logic [ADDR_W-1:0] A_EVA   = 3'd2;
  localparam logic [ADDR_W-1:0] A_EVB   = 3'd3;
  localparam logic [ADDR_W-1:0] A_EVC   = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd6;

  localparam logic [REG_W-1:0] M_CTRL = 8'h1F;
  localparam logic [REG_W-1:0] M_EVA  = 8'hFB;
  localparam logic [REG_W-1:0] M_EVC  = 8'hE0;

  localparam logic [REG_W-1:0] RST_CTRL  = 8'h08;
  localparam logic [REG_W-1:0] RST_COUNT = 8'h0F;

  localparam int STAT_EXPIRE = 5;
  localparam int STAT_APM    = 7;

  typedef enum logic [1:0] {
    SEL_LONG = 2'b00,
    SEL_OFF  = 2'b01,
    SEL_ONE  = 2'b10,
    SEL_MID  = 2'b11
  } fastoff_sel_e;
endpackage

// File: rtl/fastoff_prescaler.sv
module fastoff_prescaler
  import fastoff_pkg::*;
#(
  parameter int LO_DIV = 32768,
  parameter int HI_DIV = 60000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  input  fastoff_sel_e sel_i,
  output logic         tick_o
);
  localparam int LO_W = (LO_DIV > 2) ? $clog2(LO_DIV) : 1;
  localparam int HI_W = (HI_DIV > 2) ? $clog2(HI_DIV) : 1;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_last;
  logic            hi_last;

  always_comb begin
    lo_last = (lo_q == LO_W'(LO_DIV - 1));
    hi_last = (hi_q == HI_W'(HI_DIV - 1));
    unique case (sel_i)
      SEL_ONE:  tick_o = 1'b1;
      SEL_MID:  tick_o = lo_last;
      SEL_LONG: tick_o = lo_last && hi_last;
      default:  tick_o = 1'b0;
    endcase
  end

  // Low stage: runs in both prescaled modes.
  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) begin
      lo_q <= '0;
    end else if (sel_i == SEL_MID || sel_i == SEL_LONG) begin
      lo_q <= lo_last ? '0 : lo_q + 1'b1;
    end
  end

  // High stage: advances once per low-stage wrap, only in the long mode.
  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) begin
      hi_q <= '0;
    end else if (sel_i == SEL_LONG && lo_last) begin
      hi_q <= hi_last ? '0 : hi_q + 1'b1;
    end
  end
endmodule

// File: rtl/fastoff_downcnt.sv
module fastoff_downcnt
  import fastoff_pkg::*;
#(
  parameter int CNT_W = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic             tick_i,
  output logic             expire_o,
  output logic [CNT_W:0]   cnt_o
);
  logic [CNT_W:0] cnt_q;
  logic           at_one;

  assign at_one   = (cnt_q == (CNT_W+1)'(1));
  assign expire_o = tick_i && !load_i && at_one;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= {1'b0, RST_COUNT[CNT_W-1:0]} + 1'b1;
    end else if (load_i) begin
      cnt_q <= {1'b0, load_val_i} + 1'b1;
    end else if (tick_i) begin
      if (at_one) cnt_q <= {1'b0, base_i} + 1'b1;
      else        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fastoff_regs.sv
module fastoff_regs
  import fastoff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              set_expire_i,
  input  logic              set_apm_i,
  output fastoff_sel_e      sel_o,
  output logic              apm_armed_o,
  output logic [REG_W-1:0]  count_o,
  output logic              reload_o,
  output logic [REG_W-1:0]  reload_val_o,
  output logic [REG_W-1:0]  status_o
);
  logic [REG_W-1:0] ctrl_q, smien_q, eva_q, evb_q, evc_q, count_q, stat_q;
  logic [REG_W-1:0] stat_set;
  logic             wr_ctrl, wr_count, wr_stat;

  assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_count = wr_en_i && (wr_addr_i == A_COUNT);
  assign wr_stat  = wr_en_i && (wr_addr_i == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= RST_CTRL;
      smien_q <= '0;
      eva_q   <= '0;
      evb_q   <= '0;
      evc_q   <= '0;
      count_q <= RST_COUNT;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        A_CTRL:  ctrl_q  <= wr_data_i & M_CTRL;
        A_SMIEN: smien_q <= wr_data_i;
        A_EVA:   eva_q   <= wr_data_i & M_EVA;
        A_EVB:   evb_q   <= wr_data_i;
        A_EVC:   evc_q   <= wr_data_i & M_EVC;
        A_COUNT: count_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    stat_set = '0;
    stat_set[STAT_EXPIRE] = set_expire_i;
    stat_set[STAT_APM]    = set_apm_i;
  end

  // Status: AND-mask clear, with set events taking priority.
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (wr_stat ? (stat_q & wr_data_i) : stat_q) | stat_set;
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = ctrl_q;
      A_SMIEN: rd_data_o = smien_q;
      A_EVA:   rd_data_o = eva_q;
      A_EVB:   rd_data_o = evb_q;
      A_EVC:   rd_data_o = evc_q;
      A_COUNT: rd_data_o = count_q;
      A_STAT:  rd_data_o = stat_q;
      default: rd_data_o = '0;
    endcase
  end

  assign sel_o        = fastoff_sel_e'(ctrl_q[4:3]);
  assign apm_armed_o  = ctrl_q[0] && smien_q[7];
  assign count_o      = count_q;
  assign reload_o     = wr_ctrl || wr_count;
  assign reload_val_o = wr_count ? wr_data_i : count_q;
  assign status_o     = stat_q;
endmodule

// File: rtl/fastoff_smi_timer.sv
module fastoff_smi_timer
  import fastoff_pkg::*;
#(
  parameter int PRE_LO_DIV = 32768,
  parameter int PRE_HI_DIV = 60000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              apm_wr_i,
  output logic              smi_o
);
  fastoff_sel_e     sel;
  logic             apm_armed;
  logic             apm_hit;
  logic [REG_W-1:0] count_q;
  logic             reload;
  logic [REG_W-1:0] reload_val;
  logic [REG_W-1:0] status_q;
  logic             tick;
  logic             expire;
  logic [REG_W:0]   cnt;
  logic             smi_q;

  assign apm_hit = apm_wr_i && apm_armed;

  fastoff_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .set_expire_i (expire),
    .set_apm_i    (apm_hit),
    .sel_o        (sel),
    .apm_armed_o  (apm_armed),
    .count_o      (count_q),
    .reload_o     (reload),
    .reload_val_o (reload_val),
    .status_o     (status_q)
  );

  fastoff_prescaler #(
    .LO_DIV (PRE_LO_DIV),
    .HI_DIV (PRE_HI_DIV)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (reload),
    .sel_i     (sel),
    .tick_o    (tick)
  );

  fastoff_downcnt #(
    .CNT_W (REG_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (reload),
    .load_val_i (reload_val),
    .base_i     (count_q),
    .tick_i     (tick),
    .expire_o   (expire),
    .cnt_o      (cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) smi_q <= 1'b0;
    else        smi_q <= expire || apm_hit;
  end

  assign smi_o = smi_q;
endmodule

// File: rtl/fastoff_checker.sv
module fastoff_checker
  import fastoff_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             smi_o,
  input logic             expire,
  input logic             apm_hit,
  input logic             reload,
  input logic [1:0]       sel,
  input logic [REG_W-1:0] status_q,
  input logic [REG_W-1:0] count_q,
  input logic [REG_W:0]   cnt
);
  // R5: an expiry shows on the pin and in status bit 5 one edge later
  a_r5_expire_flags: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (smi_o && status_q[STAT_EXPIRE]));

  // R3: every SMI pulse has a timer or port cause
  a_r3_smi_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> $past(expire || apm_hit));

  // R6: the stopped mode freezes the counter
  a_r6_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01 && !reload) |=> $stable(cnt));

  // R9: bit 7 only rises after a qualified port write
  a_r9_apm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[STAT_APM]) |-> $past(apm_hit));

  // R5: counter stays within 1..count+1
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && (cnt <= ({1'b0, count_q} + 1'b1)));

  // R8: no status bit other than 5 and 7 ever becomes set
  a_r8_no_stray_status: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & 8'h5F) == 8'h00);
endmodule

bind fastoff_smi_timer fastoff_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smi_o    (smi_o),
  .expire   (expire),
  .apm_hit  (apm_hit),
  .reload   (reload),
  .sel      (sel),
  .status_q (status_q),
  .count_q  (count_q),
  .cnt      (cnt)
);

// File: tb/fastoff_smi_timer_tb.sv
module fastoff_smi_timer_tb;
  localparam int LO = 4;
  localparam int HI = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       apm_wr = 1'b0;
  logic       smi;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fastoff_smi_timer #(.PRE_LO_DIV(LO), .PRE_HI_DIV(HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .apm_wr_i(apm_wr), .smi_o(smi)
  );

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] expect_v;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hFF, 8'h1F}, '{3'd0, 8'hE9, 8'h09}, '{3'd1, 8'hA5, 8'hA5},
    '{3'd2, 8'hFF, 8'hFB}, '{3'd3, 8'h3C, 8'h3C}, '{3'd4, 8'hFF, 8'hE0},
    '{3'd4, 8'h5A, 8'h40}, '{3'd5, 8'h77, 8'h77}, '{3'd5, 8'h0F, 8'h0F},
    '{3'd7, 8'hFF, 8'h00}
  };

  task automatic check(input string req, input string what, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // Count edges until smi is seen high, at most limit.
  task automatic wait_smi(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      step();
      n++;
      if (smi) return;
    end
    n = -1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    int highs;
    repeat (3) step();
    rst_n = 1'b1;
    #1;

    // R1 reset state
    check("R1", "smi", smi, 0);
    rd(3'd0, d); check("R1", "ctrl", d, 8'h08);
    rd(3'd5, d); check("R1", "count", d, 8'h0F);
    for (int a = 1; a < 8; a++) begin
      if (a != 5) begin rd(a[2:0], d); check("R1", "other reg", d, 0); end
    end

    // R2 write masks, table driven
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].wdata);
      rd(VECS[i].addr, d);
      check("R2", "masked readback", d, VECS[i].expect_v);
    end
    rd(3'd6, d); check("R6", "status untouched while stopped", d, 0);

    // R3 period-one mode
    wr(3'd0, 8'h10);
    wr(3'd5, 8'd3);
    wait_smi(50, n); check("R3", "first smi edges N=3", n, 4);
    step(); check("R3", "pulse one cycle", smi, 0);
    // R5 periodic repeat + status bit 5
    wait_smi(50, n); check("R5", "repeat interval", n, 3);
    rd(3'd6, d); check("R5", "status bit5", d, 8'h20);
    wr(3'd5, 8'd0);
    wait_smi(10, n); check("R3", "N=0 first smi", n, 1);
    step(); check("R3", "N=0 smi every cycle", smi, 1);

    // R4 prescaled modes
    wr(3'd0, 8'h18);
    wr(3'd5, 8'd2);
    wait_smi(200, n); check("R4", "mid period N=2", n, 3 * LO);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'd1);
    wait_smi(200, n); check("R4", "long period N=1", n, 2 * LO * HI);

    // R7 restart by count rewrite
    wr(3'd0, 8'h10);
    wr(3'd5, 8'd9);
    highs = 0;
    repeat (4) begin step(); highs += smi; end
    wr(3'd5, 8'd9);
    wait_smi(50, n); check("R7", "count rewrite restarts", n, 10);
    check("R7", "no early smi", highs, 0);
    // R7 restart of prescaler by control rewrite
    wr(3'd5, 8'd0);
    wr(3'd0, 8'h18);
    repeat (2) step();
    wr(3'd0, 8'h18);
    wait_smi(50, n); check("R7", "ctrl rewrite restarts prescaler", n, LO);

    // R6 stop freezes without touching status
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h10);
    wr(3'd5, 8'd2);
    wait_smi(50, n);
    wr(3'd0, 8'h08);
    highs = 0;
    repeat (30) begin step(); highs += smi; end
    check("R6", "no smi while stopped", highs, 0);
    rd(3'd6, d); check("R6", "status kept", d, 8'h20);

    // R8 AND-mask clear
    wr(3'd6, 8'h7F); rd(3'd6, d); check("R8", "one bits keep", d, 8'h20);
    wr(3'd6, 8'hDF); rd(3'd6, d); check("R8", "zero bit clears", d, 8'h00);

    // R9 qualified port write
    wr(3'd0, 8'h09);
    wr(3'd1, 8'h80);
    apm_wr = 1'b1; step(); apm_wr = 1'b0;
    check("R9", "smi after port write", smi, 1);
    rd(3'd6, d); check("R9", "status bit7", d, 8'h80);
    step(); check("R9", "port pulse one cycle", smi, 0);
    // R8 same-cycle set beats clear
    wr(3'd6, 8'h00);
    wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h00; apm_wr = 1'b1;
    step();
    wr_en = 1'b0; apm_wr = 1'b0;
    rd(3'd6, d); check("R8", "set wins over clear", d, 8'h80);
    // R9 unqualified writes
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h08);
    apm_wr = 1'b1; step(); apm_wr = 1'b0;
    check("R9", "no smi ctrl bit0 low", smi, 0);
    wr(3'd0, 8'h09);
    wr(3'd1, 8'h7F);
    apm_wr = 1'b1; step(); apm_wr = 1'b0;
    check("R9", "no smi enable bit7 low", smi, 0);
    rd(3'd6, d); check("R9", "status unchanged", d, 0);

    // R1 reset mid-run
    wr(3'd0, 8'h10);
    wr(3'd5, 8'd0);
    rst_n = 1'b0; step(); rst_n = 1'b1; #1;
    rd(3'd0, d); check("R1", "ctrl after reset", d, 8'h08);
    rd(3'd5, d); check("R1", "count after reset", d, 8'h0F);
    rd(3'd6, d); check("R1", "status after reset", d, 0);
    check("R1", "smi after reset", smi, 0);

    done = 1;
    summary();
  end
endmodule